// File: doc/BRIEF.md
# Indirect Register Video Memory Port

This block is a byte-wide slave that a host processor uses to reach a video RAM. The RAM has no direct address range on the host bus. The host sees only two locations. The first is a select/status port: writing it picks one internal register, and reading it shows a ready flag in bit 7. The second is a data port that reads or writes whichever register is selected. Three registers do the work. Two hold the high and low bytes of a 16-bit video-memory pointer. A third is a memory window: each access to it reads or writes the RAM at the pointer and then advances the pointer by one. A configuration register holds a RAM-size bit and a 3-bit character-base field.

The RAM itself lives outside the block, behind a registered single-port request interface. Parameter `FIT_LARGE` states whether 64K or only 16K of RAM is fitted. When the configuration bit asks for 64K but only 16K is fitted, the physical address folds in the same way that real hardware folds: the pointer high byte is halved and its top bits are dropped. Several pointer values therefore reach the same cell.

There is no stall on the host side. After each accepted register or memory access, ready stays low for `BUSY_CYC` cycles, and any data-port access or select write made in that window is dropped. A host polls bit 7 of the status port until it reads 1. Once ready is 1, the data port shows the result of the last read.

Top module: `vmem_reg_port`

## Requirements
- R1: After reset the pointer is 0x0000, the configuration register is 0x00 and the selected register is 0. Ready is 1, so the status port reads 0x80. The data port reads 0x00 and no RAM request is issued.
- R2: With `host_port`=0, `host_rdata` shows the status byte: bit 7 is ready and bits 6:0 are 0. Looking at status never starts a busy window.
- R3: An accepted select write or data-port access makes ready 0 on the next cycle. Ready stays 0 for exactly `BUSY_CYC` cycles (default 4).
- R4: A select write or data-port access made while ready is 0 is ignored. It changes no register and issues no RAM request.
- R5: Register 18 reads and writes pointer bits 15:8, and register 19 reads and writes pointer bits 7:0. The select port takes the register number from `host_wdata[4:0]`.
- R6: Register 28 stores bits 7:4, where bit 4 is the large-RAM mode and bits 7:5 are the character base. Bits 3:0 always read as 0.
- R7: Reads of any register other than 18, 19, 28 and 31 return 0xFF. Writes to them have no effect.
- R8: A data write to register 31 issues a RAM write of that byte at the mapped pointer address on the cycle after acceptance. The pointer then advances by one.
- R9: A data read of register 31 issues a RAM read at the mapped pointer address on the cycle after acceptance. The RAM byte appears on the data port two cycles after acceptance. The pointer advances by one.
- R10: The pointer changes only through registers 18, 19 and 31, and it wraps from 0xFFFF to 0x0000.
- R11: With configuration bit 4 at 0, the RAM address is the pointer modulo 16K.
- R12: With bit 4 at 1 and only 16K fitted, the RAM address is {pointer[14:9], pointer[7:0]}. Pointers 0x4200 and 0x4300 both reach 0x2100, and 0x1000 and 0x1100 both reach 0x0800.
- R13: With bit 4 at 1 and 64K fitted, the RAM address is the full pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access strobe, one cycle per access |
| host_write | input | 1 | 1 = write, 0 = read |
| host_port | input | 1 | 0 = select/status port, 1 = data port; also selects what `host_rdata` shows |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or last read result, chosen by `host_port` |
| vram_en | output | 1 | RAM request this cycle |
| vram_we | output | 1 | RAM request is a write |
| vram_addr | output | 16 | Physical RAM address |
| vram_wdata | output | 8 | RAM write byte |
| vram_rdata | input | 8 | RAM read byte, valid the cycle after a read request |

## Verification
The hardest case to reach is the alias of R12. It needs a particular order of steps: the mode bit must be set through register 28, the pointer loaded through two separate select-and-write pairs, and a RAM access made through the window. A second access at a different pointer must then reach the same physical cell. The bench drives two instances, one with each fitted size, from the same host sequence. It writes through one aliasing pointer and reads through its partner. The small instance returns the written byte, and the large instance returns the byte at the distinct cell. Accesses that land inside the busy window are also forced by issuing a data write on the cycle right after an accepted one.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
  localparam int BYTE_W   = 8;
  localparam int PTR_W    = 16;
  localparam int SMALL_AW = 14;
  localparam int SEL_W    = 5;
  localparam int RDY_BIT  = 7;

  localparam logic [SEL_W-1:0] REG_PTR_HI = 5'd18;
  localparam logic [SEL_W-1:0] REG_PTR_LO = 5'd19;
  localparam logic [SEL_W-1:0] REG_CFG    = 5'd28;
  localparam logic [SEL_W-1:0] REG_WINDOW = 5'd31;

  localparam logic [BYTE_W-1:0] UNMAPPED_RD = 8'hFF;

  typedef struct packed {
    logic              en;
    logic              we;
    logic [PTR_W-1:0]  addr;
    logic [BYTE_W-1:0] wdata;
  } vram_req_t;
endpackage

// File: rtl/vmp_busy_timer.sv
module vmp_busy_timer #(
  parameter int BUSY_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= CW'(BUSY_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);

  initial begin
    if (BUSY_CYC < 2) $error("BUSY_CYC must cover the two-cycle RAM read");
  end

  p_start_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);
  p_idle_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);
endmodule

// File: rtl/vmp_ptr_unit.sv
module vmp_ptr_unit
  import vmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              step,
  input  logic [BYTE_W-1:0] wdata,
  output logic [PTR_W-1:0]  ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (step) begin
      ptr <= ptr + 1'b1;
    end else begin
      if (wr_hi) ptr[PTR_W-1:BYTE_W] <= wdata;
      if (wr_lo) ptr[BYTE_W-1:0]     <= wdata;
    end
  end

  p_step_wraps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ptr == PTR_W'($past(ptr) + 1));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(step || wr_hi || wr_lo) |=> $stable(ptr));
endmodule

// File: rtl/vmp_addr_map.sv
module vmp_addr_map
  import vmp_pkg::*;
#(
  parameter bit FIT_LARGE = 1'b0
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic             large_mode,
  output logic [PTR_W-1:0] phys
);
  localparam int HI_W  = SMALL_AW - BYTE_W;
  localparam int PAD_W = PTR_W - SMALL_AW;

  logic [PTR_W-1:0] small_addr;
  assign small_addr = {{PAD_W{1'b0}}, ptr[SMALL_AW-1:0]};

  generate
    if (FIT_LARGE) begin : g_big
      assign phys = large_mode ? ptr : small_addr;
      logic unused_top;
      assign unused_top = 1'b0;
    end else begin : g_small
      logic [PTR_W-1:0] fold_addr;
      assign fold_addr = {{PAD_W{1'b0}}, ptr[BYTE_W+HI_W:BYTE_W+1], ptr[BYTE_W-1:0]};
      assign phys = large_mode ? fold_addr : small_addr;
      logic unused_top;
      assign unused_top = ptr[PTR_W-1];
    end
  endgenerate
endmodule

// File: rtl/vmem_reg_port.sv
module vmem_reg_port
  import vmp_pkg::*;
#(
  parameter bit FIT_LARGE = 1'b0,
  parameter int BUSY_CYC  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  input  logic        host_write,
  input  logic        host_port,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        vram_en,
  output logic        vram_we,
  output logic [15:0] vram_addr,
  output logic [7:0]  vram_wdata,
  input  logic [7:0]  vram_rdata
);
  logic              ready;
  logic [SEL_W-1:0]  sel_q;
  logic [3:0]        cfg_q;
  logic [BYTE_W-1:0] hold_q;
  logic              cap_q;
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  phys;
  vram_req_t         req_q;
  logic [BYTE_W-1:0] reg_rd;

  // accepted host actions; a plain status look needs no strobe
  logic take, sel_wr, dat_acc, win_acc;
  assign take    = host_valid && ready && (host_write || host_port);
  assign sel_wr  = take && !host_port;
  assign dat_acc = take && host_port;
  assign win_acc = dat_acc && (sel_q == REG_WINDOW);

  vmp_busy_timer #(.BUSY_CYC(BUSY_CYC)) busy_i (
    .clk(clk), .rst_n(rst_n), .start(take), .ready(ready)
  );

  vmp_ptr_unit ptr_i (
    .clk(clk), .rst_n(rst_n),
    .wr_hi(dat_acc && host_write && sel_q == REG_PTR_HI),
    .wr_lo(dat_acc && host_write && sel_q == REG_PTR_LO),
    .step(win_acc), .wdata(host_wdata), .ptr(ptr)
  );

  vmp_addr_map #(.FIT_LARGE(FIT_LARGE)) map_i (
    .ptr(ptr), .large_mode(cfg_q[0]), .phys(phys)
  );

  always_comb begin
    unique case (sel_q)
      REG_PTR_HI: reg_rd = ptr[PTR_W-1:BYTE_W];
      REG_PTR_LO: reg_rd = ptr[BYTE_W-1:0];
      REG_CFG:    reg_rd = {cfg_q, 4'b0000};
      default:    reg_rd = UNMAPPED_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      cfg_q  <= '0;
      hold_q <= '0;
      cap_q  <= 1'b0;
      req_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= host_wdata[SEL_W-1:0];
      if (dat_acc && host_write && sel_q == REG_CFG) cfg_q <= host_wdata[7:4];
      req_q.en    <= win_acc;
      req_q.we    <= host_write;
      req_q.addr  <= phys;
      req_q.wdata <= host_wdata;
      cap_q       <= req_q.en && !req_q.we;
      if (cap_q)                                   hold_q <= vram_rdata;
      else if (dat_acc && !host_write && !win_acc) hold_q <= reg_rd;
    end
  end

  assign vram_en    = req_q.en;
  assign vram_we    = req_q.we;
  assign vram_addr  = req_q.addr;
  assign vram_wdata = req_q.wdata;
  assign host_rdata = host_port ? hold_q : {ready, {RDY_BIT{1'b0}}};

  p_busy_ignores_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !ready && (host_write || host_port))
      |=> ($stable(sel_q) && $stable(cfg_q) && $stable(ptr) && !vram_en));
  p_single_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vram_en |=> !vram_en);
  p_req_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vram_en |-> !ready);

  generate
    if (!FIT_LARGE) begin : g_chk_small
      p_small_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vram_en |-> (vram_addr[15:14] == 2'b00));
      p_fold_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_en && cfg_q[0]) |-> (vram_addr[7:0] == $past(ptr[7:0])));
    end
  endgenerate
endmodule

// File: tb/vmem_reg_port_tb.sv
`timescale 1ns/1ps
module vmem_reg_port_tb_top;
  localparam int BUSY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       host_valid = 1'b0, host_write = 1'b0, host_port = 1'b0;
  logic [7:0] host_wdata = 8'h00;

  logic [7:0]  rd [2];
  logic        ven [2];
  logic        vwe [2];
  logic [15:0] vad [2];
  logic [7:0]  vwd [2];
  logic [7:0]  vrd [2];

  logic [7:0] s_rd0, s_rd1, s_wd0, s_wd1, s_vr0, s_vr1;
  logic s_en0, s_en1, s_we0, s_we1;
  logic [15:0] s_ad0, s_ad1;

  vmem_reg_port #(.FIT_LARGE(1'b0), .BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_port(host_port), .host_wdata(host_wdata), .host_rdata(s_rd0),
    .vram_en(s_en0), .vram_we(s_we0), .vram_addr(s_ad0), .vram_wdata(s_wd0),
    .vram_rdata(s_vr0));

  vmem_reg_port #(.FIT_LARGE(1'b1), .BUSY_CYC(BUSY)) dut_big_i (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_port(host_port), .host_wdata(host_wdata), .host_rdata(s_rd1),
    .vram_en(s_en1), .vram_we(s_we1), .vram_addr(s_ad1), .vram_wdata(s_wd1),
    .vram_rdata(s_vr1));

  assign rd[0] = s_rd0;  assign rd[1] = s_rd1;
  assign ven[0] = s_en0; assign ven[1] = s_en1;
  assign vwe[0] = s_we0; assign vwe[1] = s_we1;
  assign vad[0] = s_ad0; assign vad[1] = s_ad1;
  assign vwd[0] = s_wd0; assign vwd[1] = s_wd1;
  assign s_vr0 = vrd[0]; assign s_vr1 = vrd[1];

  // external RAMs, sparse
  logic [7:0] ram0 [int];
  logic [7:0] ram1 [int];
  always @(posedge clk) begin
    if (s_en0) begin
      if (s_we0) ram0[int'(s_ad0)] = s_wd0;
      else vrd[0] <= ram0.exists(int'(s_ad0)) ? ram0[int'(s_ad0)] : 8'h00;
    end
    if (s_en1) begin
      if (s_we1) ram1[int'(s_ad1)] = s_wd1;
      else vrd[1] <= ram1.exists(int'(s_ad1)) ? ram1[int'(s_ad1)] : 8'h00;
    end
  end

  // reference model
  int m_sel [2], m_ptr [2], m_cfg [2], m_busy [2], m_hold [2];
  int m_pend [2], m_pval [2], m_ven [2], m_vwe [2], m_vad [2], m_vwd [2];
  int mm0 [int];
  int mm1 [int];

  function automatic int map_addr(int fit, int p, int cfg);
    if ((cfg & 16) == 0) return p % 16384;
    if (fit != 0) return p;
    return (((p >> 9) & 63) << 8) | (p & 255);
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_sel[i] = 0; m_ptr[i] = 0; m_cfg[i] = 0; m_busy[i] = 0; m_hold[i] = 0;
        m_pend[i] = 0; m_pval[i] = 0; m_ven[i] = 0; m_vwe[i] = 0; m_vad[i] = 0; m_vwd[i] = 0;
      end else begin
        automatic bit rdy = (m_busy[i] == 0);
        automatic int a;
        if (m_pend[i] > 0) begin
          m_pend[i]--;
          if (m_pend[i] == 0) m_hold[i] = m_pval[i];
        end
        if (m_busy[i] > 0) m_busy[i]--;
        m_ven[i] = 0;
        if (host_valid && rdy && (host_write || host_port)) begin
          m_busy[i] = BUSY;
          if (!host_port) m_sel[i] = int'(host_wdata) % 32;
          else begin
            a = map_addr(i, m_ptr[i], m_cfg[i]);
            case (m_sel[i])
              18: if (host_write) m_ptr[i] = (m_ptr[i] & 255) | (int'(host_wdata) << 8);
                  else m_hold[i] = m_ptr[i] >> 8;
              19: if (host_write) m_ptr[i] = (m_ptr[i] & 65280) | int'(host_wdata);
                  else m_hold[i] = m_ptr[i] & 255;
              28: if (host_write) m_cfg[i] = int'(host_wdata) & 240;
                  else m_hold[i] = m_cfg[i];
              31: begin
                m_ven[i] = 1; m_vwe[i] = host_write ? 1 : 0; m_vad[i] = a;
                m_vwd[i] = int'(host_wdata);
                if (host_write) begin
                  if (i == 0) mm0[a] = int'(host_wdata); else mm1[a] = int'(host_wdata);
                end else begin
                  if (i == 0) m_pval[i] = mm0.exists(a) ? mm0[a] : 0;
                  else        m_pval[i] = mm1.exists(a) ? mm1[a] : 0;
                  m_pend[i] = 2;
                end
                m_ptr[i] = (m_ptr[i] + 1) & 65535;
              end
              default: if (!host_write) m_hold[i] = 255;
            endcase
          end
        end
      end
    end
  end

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 2; i++) begin
        automatic int exp_rd = host_port ? m_hold[i] : ((m_busy[i] == 0) ? 128 : 0);
        chk(i == 0 ? "R9 host read path small" : "R9 host read path big", int'(rd[i]), exp_rd);
        chk("R8 RAM request strobe", int'(ven[i]), m_ven[i]);
        if (ven[i] && m_ven[i] != 0) begin
          chk("R8 RAM request kind", int'(vwe[i]), m_vwe[i]);
          chk("R11 RAM request address", int'(vad[i]), m_vad[i]);
          if (m_vwe[i] != 0) chk("R8 RAM write byte", int'(vwd[i]), m_vwd[i]);
        end
      end
    end
  end

  logic [15:0] last_a [2];
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) if (ven[i]) last_a[i] = vad[i];
  end

  task automatic bus(input logic w, input logic p, input logic [7:0] d);
    @(posedge clk); #1;
    host_valid = 1'b1; host_write = w; host_port = p; host_wdata = d;
    @(posedge clk); #1;
    host_valid = 1'b0; host_port = 1'b0;
  endtask

  task automatic wait_rdy();
    @(negedge clk);
    while (rd[0][7] == 1'b0) @(negedge clk);
  endtask

  task automatic setreg(input logic [7:0] r, input logic [7:0] v);
    bus(1'b1, 1'b0, r); wait_rdy();
    bus(1'b1, 1'b1, v); wait_rdy();
  endtask

  task automatic getreg(input logic [7:0] r, output logic [7:0] a, output logic [7:0] b);
    bus(1'b1, 1'b0, r); wait_rdy();
    bus(1'b0, 1'b1, 8'h00); wait_rdy();
    @(posedge clk); #1 host_port = 1'b1;
    @(negedge clk); a = rd[0]; b = rd[1];
    @(posedge clk); #1 host_port = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] a, b;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 status after reset", int'(rd[0]), 128);
    chk("R1 no RAM request after reset", int'(ven[0]), 0);
    @(posedge clk); #1 host_port = 1'b1;
    @(negedge clk);
    chk("R1 data port after reset", int'(rd[0]), 0);
    @(posedge clk); #1 host_port = 1'b0;
    getreg(8'd18, a, b); chk("R1 pointer high after reset", int'(a), 0);

    // R2 / R3 busy window length and status bits
    bus(1'b1, 1'b0, 8'd18);
    n = 0;
    @(negedge clk);
    chk("R2 status while busy", int'(rd[0]), 0);
    while (rd[0][7] == 1'b0) begin n++; @(negedge clk); end
    chk("R3 busy cycles", n, BUSY);
    chk("R2 status when ready", int'(rd[0]), 128);

    // R5 pointer byte registers, select uses bits 4:0 only
    setreg(8'hF2, 8'h12);
    setreg(8'd19, 8'h34);
    getreg(8'd18, a, b); chk("R5 pointer high readback", int'(a), 18);
    getreg(8'd19, a, b); chk("R5 pointer low readback", int'(a), 52);

    // R4 a write that arrives while busy is dropped
    bus(1'b1, 1'b0, 8'd18); wait_rdy();
    bus(1'b1, 1'b1, 8'hAB);
    bus(1'b1, 1'b1, 8'h77);
    wait_rdy();
    getreg(8'd18, a, b); chk("R4 busy write ignored", int'(a), 171);

    // R6 configuration bits
    setreg(8'd28, 8'hFF);
    getreg(8'd28, a, b); chk("R6 config readback", int'(a), 240);
    setreg(8'd28, 8'h00);

    // R7 unimplemented register
    setreg(8'd5, 8'h99);
    getreg(8'd5, a, b); chk("R7 unmapped read", int'(a), 255);
    getreg(8'd18, a, b); chk("R7 unmapped write no effect", int'(a), 171);

    // R11 / R8 small-mode wrap of the physical address
    setreg(8'd18, 8'h3F); setreg(8'd19, 8'hFF);
    setreg(8'd31, 8'h11);
    chk("R11 write at top of 16K", int'(last_a[0]), 16383);
    bus(1'b1, 1'b1, 8'h22); wait_rdy();
    chk("R11 wrapped to zero", int'(last_a[0]), 0);
    getreg(8'd18, a, b); chk("R10 pointer high after two steps", int'(a), 64);
    getreg(8'd19, a, b); chk("R10 pointer low after two steps", int'(a), 1);

    // R9 window reads
    setreg(8'd18, 8'h3F); setreg(8'd19, 8'hFF);
    getreg(8'd31, a, b);
    chk("R9 window read small", int'(a), 17); chk("R9 window read big", int'(b), 17);
    bus(1'b0, 1'b1, 8'h00); wait_rdy();
    @(posedge clk); #1 host_port = 1'b1;
    @(negedge clk); chk("R9 second window read", int'(rd[0]), 34);
    @(posedge clk); #1 host_port = 1'b0;

    // R12 / R13 large mode aliasing
    setreg(8'd28, 8'h10);
    setreg(8'd18, 8'h42); setreg(8'd19, 8'h00);
    setreg(8'd31, 8'h55);
    chk("R12 fold of 0x4200", int'(last_a[0]), 8448);
    chk("R13 full address 0x4200", int'(last_a[1]), 16896);
    setreg(8'd18, 8'h43); setreg(8'd19, 8'h00);
    getreg(8'd31, a, b);
    chk("R12 0x4300 reads 0x4200 byte", int'(a), 85);
    chk("R13 0x4300 distinct cell", int'(b), 0);
    setreg(8'd18, 8'h10); setreg(8'd19, 8'h00);
    setreg(8'd31, 8'hA5);
    setreg(8'd18, 8'h11); setreg(8'd19, 8'h00);
    getreg(8'd31, a, b);
    chk("R12 fold of 0x1100", int'(last_a[0]), 2048);
    chk("R12 0x1100 reads 0x1000 byte", int'(a), 165);

    // R10 wrap from 0xFFFF
    setreg(8'd18, 8'hFF); setreg(8'd19, 8'hFF);
    setreg(8'd31, 8'h5A);
    chk("R13 address 0xFFFF", int'(last_a[1]), 65535);
    getreg(8'd18, a, b); chk("R10 wrap high", int'(a), 0);
    getreg(8'd19, a, b); chk("R10 wrap low", int'(a), 0);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule